// File: doc/BRIEF.md
# Programmable No-Tone Supervisor Timer

This block watches a received-tone path and tells the host when no usable tone has arrived for a programmed time. The host loads an 8-bit setting whose low nibble is a step count. Loading only primes the period. Nothing counts until a frequency measurement completes successfully. Every later successful measurement restarts the countdown from the full period. When the signal becomes unreadable, no restarts arrive, the countdown runs out and the block raises a sticky expired flag together with a one-cycle interrupt request. The timer then stops until the next good measurement re-arms it.

The countdown advances on a 1 ms time-base strobe. Its length depends on the receive band in force when the measurement completes. An expiry that lands while a measurement is already well under way is held back, because that measurement may still succeed. The held expiry is raised if the measurement aborts, and dropped if it completes. The flag is cleared by a status read, by loading a new setting, or by reset.

Top module: `notone_supervisor`

## Requirements
- R1: After reset the expired flag and interrupt are 0 and the stored step count is 0, so a measurement completion with no setting loaded leads straight to an expiry.
- R2: Loading a setting stops any running countdown, and no expiry occurs, however many time-base strobes pass, until a measurement completes.
- R3: The period is k×20 strobes when band_sel_i is 2'b00 (high) or 2'b10 (extended) and k×40 strobes when band_sel_i is 2'b01 (mid), with k the step count. The band is taken at the measurement completion that starts the countdown. The flag rises on the clock edge after the edge that takes the final strobe.
- R4: With k = 0 the flag rises on the clock edge after the edge that takes the measurement completion.
- R5: Every measurement completion restarts the countdown from the full period.
- R6: The timer is one-shot. After an expiry no further expiry occurs until a new measurement completion.
- R7: If an expiry falls while meas_busy_i is 1 and meas_progress_i (a fraction of 2^8 full scale) is greater than 192, the flag and interrupt are withheld. A later meas_abort_i raises them on the edge that takes the abort.
- R8: A measurement completion discards a withheld expiry, so a later abort raises nothing, and it restarts the countdown.
- R9: A measurement abort with no expiry withheld leaves the countdown running from its current value. It neither restarts nor stops the countdown.
- R10: A status read clears the flag, and so does loading a setting. When an expiry and a status read fall on the same edge, the flag is set.
- R11: irq_o is high for exactly one cycle, on the edge where the flag is set.
- R12: Bits 7:4 of the setting are ignored, and only bits 3:0 form k.
- R13: A progress value of exactly 192 (75%) does not withhold an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset (general reset) |
| tick_1ms_i | input | 1 | One-cycle strobe every millisecond |
| band_sel_i | input | 2 | Receive band: 00 high, 01 mid, 10 extended, 11 treated as high |
| cfg_load_i | input | 1 | Load strobe for the setting byte |
| cfg_data_i | input | 8 | Setting byte; bits 3:0 are the step count |
| meas_done_i | input | 1 | Successful frequency measurement (one-cycle) |
| meas_abort_i | input | 1 | Aborted frequency measurement (one-cycle) |
| meas_busy_i | input | 1 | A measurement is in progress |
| meas_progress_i | input | 8 | Completed fraction of the running measurement |
| status_rd_i | input | 1 | Host status read; clears the flag |
| expired_o | output | 1 | Sticky no-tone expired flag |
| irq_o | output | 1 | One-cycle interrupt request when the flag is set |

## Verification
Only one register lies between the countdown reaching zero and the flag. The flag is therefore due one clock after the edge that takes the last strobe, or one clock after the completion edge when k is 0. A released expiry is due on the edge that takes the abort, and the interrupt falls again one clock after it rose. Each scenario drives inputs on the falling edge and counts strobes itself. It samples the flag low just after the final strobe and high one falling edge later, so an off-by-one period or an extra pipeline stage shows up at once. Withheld, discarded and continued countdowns are checked at the ports by watching whether, and at which strobe, the flag later rises.

// File: rtl/notone_pkg.sv
package notone_pkg;

   typedef enum logic [1:0] {
      BAND_HIGH = 2'b00,
      BAND_MID  = 2'b01,
      BAND_EXT  = 2'b10,
      BAND_RSVD = 2'b11
   } band_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/notone_period.sv
module notone_period
   import notone_pkg::*;
#(
   parameter int MULT_W       = 4,
   parameter int STEP_HIGH_MS = 20,
   parameter int STEP_MID_MS  = 40,
   parameter int CNT_W        = 10
) (
   input  logic [MULT_W-1:0] k_i,
   input  logic [1:0]        band_sel_i,
   output logic [CNT_W-1:0]  period_o
);

   logic [CNT_W-1:0] high_ms;
   logic [CNT_W-1:0] mid_ms;
   band_e            band;

   assign band    = band_e'(band_sel_i);
   assign high_ms = CNT_W'(k_i) * CNT_W'(STEP_HIGH_MS);

   generate
      if (STEP_MID_MS == 2 * STEP_HIGH_MS) begin : g_mid_shift
         assign mid_ms = {high_ms[CNT_W-2:0], 1'b0};
      end else begin : g_mid_mult
         assign mid_ms = CNT_W'(k_i) * CNT_W'(STEP_MID_MS);
      end
   endgenerate

   assign period_o = (band == BAND_MID) ? mid_ms : high_ms;

endmodule

// File: rtl/notone_countdown.sv
module notone_countdown #(
   parameter int CNT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic             restart_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] period_i,
   output logic             expire_o
);

   logic             running_q;
   logic [CNT_W-1:0] remain_q;

   assign expire_o = running_q && (remain_q == '0) && !restart_i && !load_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         running_q <= 1'b0;
         remain_q  <= '0;
      end else if (load_i) begin
         running_q <= 1'b0;
      end else if (restart_i) begin
         running_q <= 1'b1;
         remain_q  <= period_i;
      end else if (expire_o) begin
         running_q <= 1'b0;
      end else if (running_q && tick_i && (remain_q != '0)) begin
         remain_q  <= remain_q - 1'b1;
      end
   end

   // R2
   load_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> !running_q);

   // R5
   restart_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (restart_i && !load_i) |=> (running_q && remain_q == $past(period_i)));

   // R6
   one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_o |=> !running_q);

endmodule

// File: rtl/notone_flag.sv
module notone_flag #(
   parameter int PROG_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic              expire_i,
   input  logic              meas_done_i,
   input  logic              meas_abort_i,
   input  logic              meas_busy_i,
   input  logic [PROG_W-1:0] meas_progress_i,
   input  logic              status_rd_i,
   output logic              flag_o,
   output logic              irq_o
);

   localparam int                LATE_THR_I = (3 * (1 << PROG_W)) / 4;
   localparam logic [PROG_W-1:0] LATE_THR   = PROG_W'(LATE_THR_I);

   logic late_meas;
   logic set_now;
   logic pending_q;
   logic flag_q;
   logic irq_q;

   assign late_meas = meas_busy_i && (meas_progress_i > LATE_THR);
   assign set_now   = !load_i && ((expire_i && (!late_meas || meas_abort_i)) ||
                                  (pending_q && meas_abort_i));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pending_q <= 1'b0;
         flag_q    <= 1'b0;
         irq_q     <= 1'b0;
      end else begin
         irq_q <= set_now;
         if (load_i || meas_done_i || (pending_q && meas_abort_i))
            pending_q <= 1'b0;
         else if (expire_i && late_meas && !meas_abort_i)
            pending_q <= 1'b1;
         if (load_i)
            flag_q <= 1'b0;
         else if (set_now)
            flag_q <= 1'b1;
         else if (status_rd_i)
            flag_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;
   assign irq_o  = irq_q;

   // R7
   late_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (expire_i && late_meas && !meas_abort_i && !flag_q) |=> !flag_q);

   // R8
   done_discard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      meas_done_i |=> !pending_q);

   // R10
   read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_rd_i && !expire_i && !meas_abort_i) |=> !flag_q);

   // R11
   irq_with_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q |-> flag_q);

endmodule

// File: rtl/notone_supervisor.sv
module notone_supervisor
   import notone_pkg::*;
#(
   parameter int SET_W        = 8,
   parameter int MULT_W       = 4,
   parameter int STEP_HIGH_MS = 20,
   parameter int STEP_MID_MS  = 40,
   parameter int PROG_W       = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_1ms_i,
   input  logic [1:0]        band_sel_i,
   input  logic              cfg_load_i,
   input  logic [SET_W-1:0]  cfg_data_i,
   input  logic              meas_done_i,
   input  logic              meas_abort_i,
   input  logic              meas_busy_i,
   input  logic [PROG_W-1:0] meas_progress_i,
   input  logic              status_rd_i,
   output logic              expired_o,
   output logic              irq_o
);

   localparam int K_MAX  = (1 << MULT_W) - 1;
   localparam int MAX_MS = K_MAX * int'(max_u(STEP_HIGH_MS, STEP_MID_MS));
   localparam int CNT_W  = $clog2(MAX_MS + 1) + 1;

   initial begin
      assert (SET_W >= MULT_W && MULT_W >= 1) else $error("setting narrower than step count");
      assert (STEP_HIGH_MS >= 1 && STEP_MID_MS >= 1) else $error("step length must be positive");
      assert (PROG_W >= 2) else $error("progress needs at least two bits");
   end

   logic [MULT_W-1:0] k_q;
   logic [CNT_W-1:0]  period;
   logic              expire;
   logic              unused_hi_bits;

   generate
      if (SET_W > MULT_W) begin : g_hi_bits
         assign unused_hi_bits = ^cfg_data_i[SET_W-1:MULT_W];
      end else begin : g_no_hi_bits
         assign unused_hi_bits = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         k_q <= '0;
      else if (cfg_load_i)
         k_q <= cfg_data_i[MULT_W-1:0];
   end

   notone_period #(
      .MULT_W      (MULT_W),
      .STEP_HIGH_MS(STEP_HIGH_MS),
      .STEP_MID_MS (STEP_MID_MS),
      .CNT_W       (CNT_W)
   ) i_period (
      .k_i       (k_q),
      .band_sel_i(band_sel_i),
      .period_o  (period)
   );

   notone_countdown #(
      .CNT_W(CNT_W)
   ) i_countdown (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (cfg_load_i),
      .restart_i(meas_done_i),
      .tick_i   (tick_1ms_i),
      .period_i (period),
      .expire_o (expire)
   );

   notone_flag #(
      .PROG_W(PROG_W)
   ) i_flag (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .load_i         (cfg_load_i),
      .expire_i       (expire),
      .meas_done_i    (meas_done_i),
      .meas_abort_i   (meas_abort_i),
      .meas_busy_i    (meas_busy_i),
      .meas_progress_i(meas_progress_i),
      .status_rd_i    (status_rd_i),
      .flag_o         (expired_o),
      .irq_o          (irq_o)
   );

   // R12
   upper_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_load_i |=> (k_q == $past(cfg_data_i[MULT_W-1:0])));

endmodule

// File: tb/test_notone_supervisor.sv
module test_notone_supervisor;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [1:0] band_sel = 2'b00;
   logic       load_stb = 1'b0;
   logic [7:0] load_data = 8'h00;
   logic       meas_done = 1'b0;
   logic       meas_abort = 1'b0;
   logic       meas_busy = 1'b0;
   logic [7:0] meas_progress = 8'h00;
   logic       status_rd = 1'b0;
   logic       expired;
   logic       irq;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   notone_supervisor i_notone_supervisor (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .tick_1ms_i     (tick),
      .band_sel_i     (band_sel),
      .cfg_load_i     (load_stb),
      .cfg_data_i     (load_data),
      .meas_done_i    (meas_done),
      .meas_abort_i   (meas_abort),
      .meas_busy_i    (meas_busy),
      .meas_progress_i(meas_progress),
      .status_rd_i    (status_rd),
      .expired_o      (expired),
      .irq_o          (irq)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
   endtask

   task automatic do_load(input logic [7:0] v);
      @(negedge clk) begin load_stb = 1'b1; load_data = v; end
      @(negedge clk) load_stb = 1'b0;
   endtask

   task automatic do_done();
      @(negedge clk) meas_done = 1'b1;
      @(negedge clk) meas_done = 1'b0;
   endtask

   task automatic do_abort();
      @(negedge clk) meas_abort = 1'b1;
      @(negedge clk) meas_abort = 1'b0;
   endtask

   task automatic do_read();
      @(negedge clk) status_rd = 1'b1;
      @(negedge clk) status_rd = 1'b0;
   endtask

   // Countdown already started: expect the flag exactly after p strobes.
   task automatic run_period(input string req, input int p);
      if (p > 0) begin
         ticks(p - 1);
         @(negedge clk);
         chk({req, " flag low before last strobe"}, expired, 1'b0);
         ticks(1);
      end
      chk({req, " flag low at last strobe"}, expired, 1'b0);
      @(negedge clk);
      chk({req, " flag high after period"}, expired, 1'b1);
      chk({req, " R11 irq high with flag"}, irq, 1'b1);
      @(negedge clk);
      chk({req, " R11 irq one cycle"}, irq, 1'b0);
   endtask

   task automatic t_reset();
      chk("R1 flag after reset", expired, 1'b0);
      chk("R1 irq after reset", irq, 1'b0);
      do_done();
      run_period("R1 zero setting", 0);
   endtask

   task automatic t_no_start();
      do_load(8'h01);
      chk("R10 load clears flag", expired, 1'b0);
      ticks(60);
      chk("R2 no expiry before measurement", expired, 1'b0);
   endtask

   task automatic t_bands();
      band_sel = 2'b00; do_load(8'h02); do_done();
      run_period("R3 high band k=2", 40); do_read();
      band_sel = 2'b01; do_load(8'h03); do_done();
      run_period("R3 mid band k=3", 120); do_read();
      band_sel = 2'b10; do_load(8'h05); do_done();
      run_period("R3 extended band k=5", 100); do_read();
      band_sel = 2'b00;
   endtask

   task automatic t_upper_bits();
      do_load(8'hA1); do_done();
      run_period("R12 upper bits ignored", 20); do_read();
   endtask

   task automatic t_zero();
      band_sel = 2'b01; do_load(8'h00); do_done();
      run_period("R4 zero period mid band", 0); do_read();
      band_sel = 2'b00;
   endtask

   task automatic t_restart();
      do_load(8'h01); do_done(); ticks(15); do_done();
      run_period("R5 restart on completion", 20);
   endtask

   task automatic t_one_shot();
      do_read();
      chk("R10 read clears flag", expired, 1'b0);
      ticks(50);
      chk("R6 no second expiry", expired, 1'b0);
   endtask

   task automatic t_late_abort();
      do_load(8'h01); do_done(); ticks(19);
      meas_busy = 1'b1; meas_progress = 8'd200;
      ticks(1); @(negedge clk);
      chk("R7 expiry withheld", expired, 1'b0);
      repeat (5) @(negedge clk);
      chk("R7 still withheld", expired, 1'b0);
      do_abort();
      meas_busy = 1'b0; meas_progress = 8'd0;
      chk("R7 abort releases flag", expired, 1'b1);
      chk("R7 abort releases irq", irq, 1'b1);
      do_read();
   endtask

   task automatic t_threshold();
      do_load(8'h01); do_done();
      meas_busy = 1'b1; meas_progress = 8'd192;
      run_period("R13 exactly 75% not withheld", 20);
      meas_busy = 1'b0; meas_progress = 8'd0;
      do_read();
   endtask

   task automatic t_late_done();
      do_load(8'h01); do_done(); ticks(19);
      meas_busy = 1'b1; meas_progress = 8'd250;
      ticks(1); @(negedge clk);
      chk("R8 expiry pending", expired, 1'b0);
      meas_busy = 1'b0; meas_progress = 8'd0;
      do_done();
      chk("R8 completion drops pending", expired, 1'b0);
      do_abort();
      chk("R8 abort after discard raises nothing", expired, 1'b0);
      run_period("R8 countdown restarted", 20); do_read();
   endtask

   task automatic t_abort_continues();
      do_load(8'h01); do_done(); ticks(8); do_abort();
      run_period("R9 abort keeps countdown", 12); do_read();
   endtask

   task automatic t_read_collision();
      do_load(8'h01); do_done(); ticks(20);
      status_rd = 1'b1;
      @(negedge clk) status_rd = 1'b0;
      chk("R10 set wins over read", expired, 1'b1);
      do_read();
      chk("R10 later read clears", expired, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_start();
      t_bands();
      t_upper_bits();
      t_zero();
      t_restart();
      t_one_shot();
      t_late_abort();
      t_threshold();
      t_late_done();
      t_abort_continues();
      t_read_collision();
      report();
   end

endmodule